// File: doc/BRIEF.md
# Nested Three-Level Interrupt Arbiter

This block collects interrupt sources onto ten vector slots, picks one winner per cycle and presents its vector address to the processor together with a take strobe. Each slot carries one level-select bit. The first two slots choose between the top level and the bottom level. The remaining eight slots choose between the middle level and the bottom level. A slot is served only if its level is strictly above the level currently in service, so interrupts can nest up to three deep.

Each slot has a group of sources. An enable bit gates each source. A pulse on any enabled source of a slot sets that slot's pending flag. The processor acknowledges a presented vector. This clears the slot's pending flag and records the served level. A return pulse later releases that level and restores the one below it.

Top module: `nested_irq_arbiter`

## Requirements
- R1: After reset, `take` is 0, `cur_lvl` is 0 (nothing in service) and no slot is pending.
- R2: Slots are indexed from 0 to 9. The vector address of slot i is 3 + 8*i, so slot 0 is 0x03 and slot 9 is 0x4B.
- R3: The level codes are 0 = none, 1 = low, 2 = high and 3 = top. When `lvl_sel[i]` is 1, slot i has level 3 if i is 0 or 1, and level 2 for any other i. When `lvl_sel[i]` is 0, slot i has level 1.
- R4: When pending slots differ in level, the slot with the highest level is presented.
- R5: When the highest level is shared by several pending slots, the one with the lowest index, and so the smallest vector address, is presented.
- R6: A pending slot whose level is equal to or below `cur_lvl` is not presented. It stays pending.
- R7: Slot i is fed by source bits `src_req[4*i+3:4*i]`, which are OR-ed together. A source whose `src_en` bit is 0 does not set the pending flag.
- R8: A source pulse sampled at one rising edge raises `take` after the next rising edge. An edge that sees `ack` with `take` high clears the presented slot's pending flag, sets `cur_lvl` to that slot's level and lowers `take`.
- R9: An edge that sees `reti` removes the highest in-service level and `cur_lvl` falls to the level below it. When nothing is in service, `reti` has no effect.
- R10: While `irq_en` is 0, `take` stays 0 and pending flags are kept. Once `irq_en` returns to 1, the kept request is presented after one edge.
- R11: A slot that is not acknowledged stays pending. It is presented once `cur_lvl` falls below its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 40 | Source event pulses, four per slot |
| src_en | input | 40 | Per-source enable |
| lvl_sel | input | 10 | Per-slot level select (1 = upper choice) |
| irq_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Processor acknowledge of the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| take | output | 1 | A vector is presented |
| vec_addr | output | 8 | Vector address of the presented slot |
| cur_lvl | output | 2 | Level currently in service |

## Verification
- A source pulse reaches its pending flag at the first edge and `take` at the second. The bench therefore drives on falling edges and checks `take` and `vec_addr` one full cycle after the pulse is removed.
- `ack` and `reti` each act on a single edge, so `cur_lvl` is checked at the falling edge right after that edge.
- A request that was held back during service is checked one edge after the return that releases it.
- The test sweeps every slot, level choice and ordered pair of slots. The bench computes each expected winner from the level rule and the index rule.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic [1:0] {
      LV_NONE = 2'd0,
      LV_L    = 2'd1,
      LV_H    = 2'd2,
      LV_X    = 2'd3
   } irq_lvl_t;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter int NUM_SLOTS    = 10,
   parameter int SRC_PER_SLOT = 4,
   parameter int IDX_W        = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0]  src_req,
   input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0]  src_en,
   input  logic                               clr_valid,
   input  logic [IDX_W-1:0]                   clr_idx,
   output logic [NUM_SLOTS-1:0]               pend
);
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic hit;
      assign hit = |(src_req[g*SRC_PER_SLOT +: SRC_PER_SLOT] &
                     src_en[g*SRC_PER_SLOT +: SRC_PER_SLOT]);
      always_ff @(posedge clk) begin
         if (!rst_n) pend[g] <= 1'b0;
         else        pend[g] <= hit | (pend[g] & ~(clr_valid && (clr_idx == IDX_W'(g))));
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick import irq_arb_pkg::*; #(
   parameter int NUM_SLOTS     = 10,
   parameter int NUM_X_CAPABLE = 2,
   parameter int IDX_W         = 4
) (
   input  logic [NUM_SLOTS-1:0] pend,
   input  logic [NUM_SLOTS-1:0] lvl_sel,
   output logic                 win_valid,
   output logic [IDX_W-1:0]     win_idx,
   output irq_lvl_t             win_lvl
);
   irq_lvl_t slot_lvl [NUM_SLOTS];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lvl
      if (g < NUM_X_CAPABLE) begin : g_top
         assign slot_lvl[g] = !pend[g] ? LV_NONE : (lvl_sel[g] ? LV_X : LV_L);
      end else begin : g_mid
         assign slot_lvl[g] = !pend[g] ? LV_NONE : (lvl_sel[g] ? LV_H : LV_L);
      end
   end

   // descending scan with >= leaves the lowest index among the highest level
   always_comb begin
      win_lvl = LV_NONE;
      win_idx = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (slot_lvl[i] != LV_NONE && slot_lvl[i] >= win_lvl) begin
            win_lvl = slot_lvl[i];
            win_idx = IDX_W'(i);
         end
      end
      win_valid = (win_lvl != LV_NONE);
   end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack import irq_arb_pkg::*; (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  irq_lvl_t push_lvl,
   input  logic     pop,
   output irq_lvl_t cur_lvl
);
   logic [2:0] in_svc, nxt;

   always_comb begin
      nxt = in_svc;
      if (push) begin
         case (push_lvl)
            LV_L:    nxt[0] = 1'b1;
            LV_H:    nxt[1] = 1'b1;
            LV_X:    nxt[2] = 1'b1;
            default: ;
         endcase
      end else if (pop) begin
         if (nxt[2])      nxt[2] = 1'b0;
         else if (nxt[1]) nxt[1] = 1'b0;
         else             nxt[0] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) in_svc <= 3'b000;
      else        in_svc <= nxt;
   end

   assign cur_lvl = in_svc[2] ? LV_X : in_svc[1] ? LV_H : in_svc[0] ? LV_L : LV_NONE;
endmodule

// File: rtl/nested_irq_arbiter.sv
module nested_irq_arbiter import irq_arb_pkg::*; #(
   parameter int NUM_SLOTS     = 10,
   parameter int SRC_PER_SLOT  = 4,
   parameter int NUM_X_CAPABLE = 2,
   parameter int VEC_BASE      = 3,
   parameter int VEC_STRIDE    = 8,
   parameter int VEC_W         = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0]  src_req,
   input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0]  src_en,
   input  logic [NUM_SLOTS-1:0]               lvl_sel,
   input  logic                               irq_en,
   input  logic                               ack,
   input  logic                               reti,
   output logic                               take,
   output logic [VEC_W-1:0]                   vec_addr,
   output logic [1:0]                         cur_lvl
);
   localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam int VEC_LAST = VEC_BASE + (NUM_SLOTS - 1) * VEC_STRIDE;

   if (NUM_X_CAPABLE > NUM_SLOTS) begin : g_bad_xcap
      $error("NUM_X_CAPABLE exceeds NUM_SLOTS");
   end
   if (VEC_LAST >= (1 << VEC_W)) begin : g_bad_vecw
      $error("VEC_W too narrow for the last vector address");
   end
   if (SRC_PER_SLOT < 1) begin : g_bad_src
      $error("SRC_PER_SLOT must be at least 1");
   end

   logic [NUM_SLOTS-1:0] pend;
   logic                 win_valid;
   logic [IDX_W-1:0]     win_idx;
   irq_lvl_t             win_lvl;
   irq_lvl_t             svc_lvl;
   logic                 take_q;
   logic [IDX_W-1:0]     idx_q;
   irq_lvl_t             lvl_q;
   logic                 acked, accept;

   assign acked  = take_q && ack;
   assign accept = irq_en && win_valid && (win_lvl > svc_lvl);

   irq_pending #(.NUM_SLOTS(NUM_SLOTS), .SRC_PER_SLOT(SRC_PER_SLOT), .IDX_W(IDX_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
      .clr_valid(acked), .clr_idx(idx_q), .pend(pend));

   irq_pick #(.NUM_SLOTS(NUM_SLOTS), .NUM_X_CAPABLE(NUM_X_CAPABLE), .IDX_W(IDX_W)) u_pick (
      .pend(pend), .lvl_sel(lvl_sel), .win_valid(win_valid),
      .win_idx(win_idx), .win_lvl(win_lvl));

   irq_level_stack u_stack (
      .clk(clk), .rst_n(rst_n), .push(acked), .push_lvl(lvl_q),
      .pop(reti && !acked), .cur_lvl(svc_lvl));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         idx_q  <= '0;
         lvl_q  <= LV_NONE;
      end else begin
         take_q <= accept && !acked;
         if (accept && !acked) begin
            idx_q <= win_idx;
            lvl_q <= win_lvl;
         end
      end
   end

   assign take     = take_q;
   assign vec_addr = take_q ? VEC_W'(VEC_BASE) + VEC_W'(idx_q) * VEC_W'(VEC_STRIDE) : '0;
   assign cur_lvl  = svc_lvl;
endmodule

// File: rtl/nested_irq_arbiter_chk.sv
module nested_irq_arbiter_chk #(
   parameter int NUM_SLOTS = 10,
   parameter int IDX_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 irq_en,
   input logic                 ack,
   input logic                 reti,
   input logic                 take,
   input logic [1:0]           cur_lvl,
   input logic [1:0]           take_lvl,
   input logic [IDX_W-1:0]     take_idx,
   input logic [NUM_SLOTS-1:0] pend
);
   // R6
   above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (take_lvl > cur_lvl));
   // R8
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ack) |=> !take);
   // R8
   ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ack) |=> (cur_lvl == $past(take_lvl)));
   // R11
   pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pend[take_idx]);
   // R10
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !take);
   // R9
   pop_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !(take && ack) && cur_lvl != 2'd0) |=> (cur_lvl < $past(cur_lvl)));
endmodule

bind nested_irq_arbiter nested_irq_arbiter_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .ack(ack), .reti(reti),
   .take(take), .cur_lvl(cur_lvl), .take_lvl(lvl_q), .take_idx(idx_q), .pend(pend));

// File: tb/nested_irq_arbiter_test.sv
`timescale 1ns/1ps
module nested_irq_arbiter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [39:0] src_req = '0;
   logic [39:0] src_en = '1;
   logic [9:0]  lvl_sel = '0;
   logic        irq_en = 1'b1;
   logic        ack = 1'b0;
   logic        reti = 1'b0;
   logic        take;
   logic [7:0]  vec_addr;
   logic [1:0]  cur_lvl;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   nested_irq_arbiter uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
      .lvl_sel(lvl_sel), .irq_en(irq_en), .ack(ack), .reti(reti),
      .take(take), .vec_addr(vec_addr), .cur_lvl(cur_lvl));

   function automatic int exp_lvl(int i, bit sel);
      return sel ? ((i < 2) ? 3 : 2) : 1;
   endfunction

   function automatic int exp_vec(int i);
      return 3 + 8 * i;
   endfunction

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src_req = '0; ack = 1'b0; reti = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // returns when a take caused by the pulse is visible
   task automatic pulse(input logic [39:0] v);
      src_req = v;
      @(negedge clk);
      src_req = '0;
      @(negedge clk);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic do_reti();
      reti = 1'b1;
      @(negedge clk);
      reti = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      check("R1 take", int'(take), 0);
      check("R1 cur_lvl", int'(cur_lvl), 0);
      repeat (2) @(negedge clk);
      check("R1 nothing pending", int'(take), 0);

      // single slot sweep: R2, R3, R7, R8, R9
      for (int s = 0; s < 10; s++) begin
         for (int sel = 0; sel < 2; sel++) begin
            do_reset();
            lvl_sel = '0;
            lvl_sel[s] = sel[0];
            pulse(40'd1 << (s * 4 + (s + sel) % 4));
            check("R8 take raised", int'(take), 1);
            check("R2 vector", int'(vec_addr), exp_vec(s));
            do_ack();
            check("R8 take dropped", int'(take), 0);
            check("R3 level", int'(cur_lvl), exp_lvl(s, sel[0]));
            do_reti();
            check("R9 pop to none", int'(cur_lvl), 0);
         end
      end

      // ordered pairs: R4, R5, R6, R11
      for (int a = 0; a < 10; a++) begin
         for (int b = 0; b < 10; b++) begin
            if (a == b) continue;
            for (int m = 0; m < 4; m++) begin
               int la, lb, w, lo, lw, ll;
               do_reset();
               lvl_sel = '0;
               lvl_sel[a] = m[0];
               lvl_sel[b] = m[1];
               la = exp_lvl(a, m[0]);
               lb = exp_lvl(b, m[1]);
               if (la > lb)      begin w = a; lo = b; end
               else if (lb > la) begin w = b; lo = a; end
               else              begin w = (a < b) ? a : b; lo = (a < b) ? b : a; end
               lw = (w == a) ? la : lb;
               ll = (w == a) ? lb : la;
               pulse((40'd1 << (a * 4)) | (40'd1 << (b * 4)));
               if (la != lb) check("R4 winner", int'(vec_addr), exp_vec(w));
               else          check("R5 winner", int'(vec_addr), exp_vec(w));
               do_ack();
               check("R8 level of winner", int'(cur_lvl), lw);
               @(negedge clk);
               check("R6 loser held back", int'(take), 0);
               do_reti();
               @(negedge clk);
               check("R11 loser take", int'(take), 1);
               check("R11 loser vector", int'(vec_addr), exp_vec(lo));
               do_ack();
               check("R3 loser level", int'(cur_lvl), ll);
            end
         end
      end

      // nesting across three levels: R6, R9, R11
      do_reset();
      lvl_sel = '0;
      lvl_sel[0] = 1'b1; lvl_sel[3] = 1'b1; lvl_sel[4] = 1'b1;
      pulse(40'd1 << (5 * 4));
      do_ack();
      check("R8 nest low", int'(cur_lvl), 1);
      pulse(40'd1 << (3 * 4 + 2));
      check("R6 high over low", int'(vec_addr), exp_vec(3));
      do_ack();
      check("R8 nest high", int'(cur_lvl), 2);
      pulse(40'd1 << (4 * 4 + 1));
      check("R6 equal level rejected", int'(take), 0);
      pulse(40'd1 << 3);
      check("R6 top over high", int'(vec_addr), exp_vec(0));
      do_ack();
      check("R8 nest top", int'(cur_lvl), 3);
      do_reti();
      check("R9 pop top", int'(cur_lvl), 2);
      @(negedge clk);
      check("R6 still equal", int'(take), 0);
      do_reti();
      check("R9 pop high", int'(cur_lvl), 1);
      @(negedge clk);
      check("R11 held high presented", int'(vec_addr), exp_vec(4));
      do_ack();
      check("R8 high again", int'(cur_lvl), 2);
      do_reti();
      do_reti();
      check("R9 back to none", int'(cur_lvl), 0);
      do_reti();
      check("R9 empty pop ignored", int'(cur_lvl), 0);

      // source gating: R7
      do_reset();
      lvl_sel = '0;
      src_en = '1;
      src_en[6 * 4 + 2] = 1'b0;
      pulse(40'd1 << (6 * 4 + 2));
      check("R7 disabled source", int'(take), 0);
      pulse(40'd1 << (6 * 4 + 1));
      check("R7 enabled source", int'(vec_addr), exp_vec(6));
      src_en = '1;

      // global enable: R10
      do_reset();
      irq_en = 1'b0;
      pulse(40'd1 << (2 * 4 + 3));
      check("R10 gated", int'(take), 0);
      repeat (3) @(negedge clk);
      check("R10 still gated", int'(take), 0);
      irq_en = 1'b1;
      @(negedge clk);
      check("R10 released take", int'(take), 1);
      check("R10 released vector", int'(vec_addr), exp_vec(2));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule